// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small translation cache that sits between an address generator and the page table walker. It maps a virtual page number to a physical page number. A lookup that hits returns the physical page number in the same cycle, so no page table entry has to be fetched. A lookup that misses tells the caller to fetch the entry from memory. The caller then writes the result back through the fill port. A single invalidate-all input drops every cached translation at once, for example after the address space changes.

The page number is split into two parts. The low bits select a set and the upper bits are kept as the tag. All ways of the selected set are compared in parallel. When a fill arrives, a way that already holds the same page is overwritten first. If there is none, the lowest free way is used. If the set is full, a per-set round-robin pointer names the victim. The page offset is not used by the block. The caller appends it to the returned physical page number to form the physical address.

Top module: `xlat_tlb`

## Requirements
- R1: With default parameters the block holds 16 entries as 4 sets of 4 ways. The set is page number bits [1:0] and the tag is page number bits [7:2].
- R2: A lookup hits when a valid entry in the selected set has a matching tag. On a hit, `lk_hit` is 1 and `lk_ppn` is the stored physical page number. Both outputs are combinational on the current contents.
- R3: On a miss, `lk_hit` is 0 and `lk_ppn` is 0.
- R4: A fill accepted in one cycle is not visible to a lookup in that same cycle. It is visible to lookups from the next cycle on.
- R5: A fill whose page number is already present overwrites that way. A set never holds two valid copies of one tag.
- R6: A fill with no matching way takes the lowest-numbered invalid way of its set.
- R7: A fill into a full set with no matching way replaces the way named by that set's round-robin pointer. Each set has its own pointer. A pointer starts at 0 and steps by one, modulo the way count, on every accepted fill to its set.
- R8: `inv_all` clears every valid bit and every pointer by the next cycle. A fill in the same cycle as `inv_all` is dropped.
- R9: An active-low reset leaves the same state as `inv_all`: every lookup misses and every pointer is 0.
- R10: Virtual address 0x03D4 gives page 0x0F, set 3 and tag 0x03. After that page is filled with physical page 0x0D, the physical address is 0x354. Virtual address 0x0020 (page 0x00) misses when set 0 holds only other tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 8 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_ppn | output | 6 | Physical page number on a hit, zero on a miss |
| fl_en | input | 1 | Write a translation this cycle |
| fl_vpn | input | 8 | Virtual page number of the translation being written |
| fl_ppn | input | 6 | Physical page number of the translation being written |
| inv_all | input | 1 | Drop every translation and reset every pointer |

## Verification
The assertions assume that `lk_vpn`, `fl_en` and `inv_all` are never unknown after reset. They also assume that `fl_vpn` and `fl_ppn` are defined whenever `fl_en` is high.

The assertions make no assumption about the order or overlap of fills, lookups and invalidates. The bench uses this freedom on purpose: it fills and looks up the same page in one cycle, fills while invalidating, and refills pages already present. It drives every input from a known value starting at time zero.

The random phase draws pages from a narrow range, so that sets overflow often and the round-robin pointers wrap many times.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // Default geometry, shared by the block and its bench.
   localparam int unsigned XLAT_VPN_W = 8;
   localparam int unsigned XLAT_PPN_W = 6;
   localparam int unsigned XLAT_SETS  = 4;
   localparam int unsigned XLAT_WAYS  = 4;

   // Reason a fill way was chosen.
   typedef enum logic [1:0] {
      VSRC_MATCH = 2'd0,
      VSRC_FREE  = 2'd1,
      VSRC_RR    = 2'd2
   } vsrc_e;

endpackage

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           key,
   output logic [WAYS-1:0]            hit_vec
);

   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("xlat_way_cmp: WAYS must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("xlat_way_cmp: TAG_W must be at least 1");
      end
   endgenerate

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_cmp
         assign hit_vec[w] = vld[w] && (tags[w] == key);
      end
   endgenerate

   // R5
   one_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick
   import xlat_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WAYS-1:0]  vld,
   input  logic [WAYS-1:0]  hv,
   input  logic [WAY_W-1:0] rr_ptr,
   output logic [WAY_W-1:0] way
);

   vsrc_e src;

   generate
      if ((1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("xlat_victim_pick: WAYS must be a power of two");
      end
   endgenerate

   always_comb begin
      logic found_m;
      logic found_f;
      logic [WAY_W-1:0] way_m;
      logic [WAY_W-1:0] way_f;
      found_m = 1'b0;
      found_f = 1'b0;
      way_m   = '0;
      way_f   = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hv[i] && !found_m) begin
            found_m = 1'b1;
            way_m   = WAY_W'(i);
         end
         if (!vld[i] && !found_f) begin
            found_f = 1'b1;
            way_f   = WAY_W'(i);
         end
      end
      if (found_m) begin
         src = VSRC_MATCH;
         way = way_m;
      end else if (found_f) begin
         src = VSRC_FREE;
         way = way_f;
      end else begin
         src = VSRC_RR;
         way = rr_ptr;
      end
   end

   // R5
   match_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hv != '0) |-> (hv[way] && src == VSRC_MATCH));

   // R6
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hv == '0 && !(&vld)) |-> (!vld[way] && src == VSRC_FREE));

   // R7
   rr_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == VSRC_RR) |-> (&vld));

endmodule

// File: rtl/xlat_rr_ring.sv
module xlat_rr_ring #(
   parameter int unsigned SETS  = 4,
   parameter int unsigned WAYS  = 4,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       adv,
   input  logic [IDX_W-1:0]           adv_set,
   output logic [SETS-1:0][WAY_W-1:0] ptrs
);

   genvar s;
   generate
      for (s = 0; s < SETS; s++) begin : g_ptr
         logic step;
         assign step = adv && (adv_set == IDX_W'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ptrs[s] <= '0;
            end else if (clr) begin
               ptrs[s] <= '0;
            end else if (step) begin
               ptrs[s] <= ptrs[s] + 1'b1;
            end
         end

         // R7
         rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !clr && adv_set == IDX_W'(s)) |=> ptrs[s] == $past(ptrs[s]) + 1'b1);

         // R8
         rr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> ptrs[s] == '0);
      end
   endgenerate

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int unsigned VPN_W = XLAT_VPN_W,
   parameter int unsigned PPN_W = XLAT_PPN_W,
   parameter int unsigned SETS  = XLAT_SETS,
   parameter int unsigned WAYS  = XLAT_WAYS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fl_en,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [PPN_W-1:0] fl_ppn,
   input  logic             inv_all
);

   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned TAG_W = VPN_W - IDX_W;

   generate
      if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
         $error("xlat_tlb: SETS must be a power of two, at least 2");
      end
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("xlat_tlb: WAYS must be a power of two, at least 2");
      end
      if (VPN_W <= IDX_W) begin : g_bad_vpn
         $error("xlat_tlb: VPN_W must exceed the set index width");
      end
   endgenerate

   // Entry storage
   logic [SETS-1:0][WAYS-1:0]            vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn_q;

   // Address split
   logic [IDX_W-1:0] lk_set, fl_set;
   logic [TAG_W-1:0] lk_tag, fl_tag;
   assign lk_set = lk_vpn[IDX_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
   assign fl_set = fl_vpn[IDX_W-1:0];
   assign fl_tag = fl_vpn[VPN_W-1:IDX_W];

   // Lookup side
   logic [WAYS-1:0] lk_hv;

   xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_q[lk_set]),
      .tags    (tag_q[lk_set]),
      .key     (lk_tag),
      .hit_vec (lk_hv)
   );

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < WAYS; i++) begin
         lk_ppn = lk_ppn | ({PPN_W{lk_hv[i]}} & ppn_q[lk_set][i]);
      end
   end
   assign lk_hit = |lk_hv;

   // Fill side
   logic [WAYS-1:0]            fl_hv;
   logic [SETS-1:0][WAY_W-1:0] rr_ptrs;
   logic [WAY_W-1:0]           vict;
   logic                       fl_go;

   assign fl_go = fl_en && !inv_all;

   xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_q[fl_set]),
      .tags    (tag_q[fl_set]),
      .key     (fl_tag),
      .hit_vec (fl_hv)
   );

   xlat_victim_pick #(.WAYS(WAYS)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (vld_q[fl_set]),
      .hv     (fl_hv),
      .rr_ptr (rr_ptrs[fl_set]),
      .way    (vict)
   );

   xlat_rr_ring #(.SETS(SETS), .WAYS(WAYS)) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (inv_all),
      .adv     (fl_go),
      .adv_set (fl_set),
      .ptrs    (rr_ptrs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (inv_all) begin
         vld_q <= '0;
      end else if (fl_en) begin
         vld_q[fl_set][vict] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fl_go) begin
         tag_q[fl_set][vict] <= fl_tag;
         ppn_q[fl_set][vict] <= fl_ppn;
      end
   end

   // R8
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld_q == '0));

   // R4
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go |=> (vld_q[$past(fl_set)][$past(vict)]
                 && tag_q[$past(fl_set)][$past(vict)] == $past(fl_tag)
                 && ppn_q[$past(fl_set)][$past(vict)] == $past(fl_ppn)));

   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppn == '0));

endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;

   localparam int PERIOD = 20;
   localparam int NS = 4;
   localparam int NW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lk_vpn = '0;
   logic       lk_hit;
   logic [5:0] lk_ppn;
   logic       fl_en = 1'b0;
   logic [7:0] fl_vpn = '0;
   logic [5:0] fl_ppn = '0;
   logic       inv_all = 1'b0;

   int checks = 0;
   int fails = 0;

   // reference model
   int m_v [NS][NW];
   int m_t [NS][NW];
   int m_p [NS][NW];
   int m_rr[NS];

   always #(PERIOD/2) clk = ~clk;

   xlat_tlb u_xlat_tlb (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_vpn  (lk_vpn),
      .lk_hit  (lk_hit),
      .lk_ppn  (lk_ppn),
      .fl_en   (fl_en),
      .fl_vpn  (fl_vpn),
      .fl_ppn  (fl_ppn),
      .inv_all (inv_all)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < NS; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < NW; w++) m_v[s][w] = 0;
      end
   endtask

   task automatic model_look(input int vpn, output int hit, output int ppn);
      int s;
      int t;
      s = vpn % NS;
      t = vpn / NS;
      hit = 0;
      ppn = 0;
      for (int w = 0; w < NW; w++)
         if (m_v[s][w] != 0 && m_t[s][w] == t) begin
            hit = 1;
            ppn = m_p[s][w];
         end
   endtask

   task automatic model_fill(input int vpn, input int ppn);
      int s;
      int t;
      int pick;
      s = vpn % NS;
      t = vpn / NS;
      pick = -1;
      for (int w = 0; w < NW; w++)
         if (pick < 0 && m_v[s][w] != 0 && m_t[s][w] == t) pick = w;
      for (int w = 0; w < NW; w++)
         if (pick < 0 && m_v[s][w] == 0) pick = w;
      if (pick < 0) pick = m_rr[s];
      m_v[s][pick] = 1;
      m_t[s][pick] = t;
      m_p[s][pick] = ppn;
      m_rr[s] = (m_rr[s] + 1) % NW;
   endtask

   // One clock: drive, compare the lookup against the model, then update the model.
   task automatic cyc(input string req, input int lv, input bit fe, input int fv,
                      input int fp, input bit inv);
      int eh;
      int ep;
      @(negedge clk);
      lk_vpn  = 8'(lv);
      fl_en   = fe;
      fl_vpn  = 8'(fv);
      fl_ppn  = 6'(fp);
      inv_all = inv;
      #5;
      model_look(lv, eh, ep);
      chk({req, " hit"}, int'(lk_hit), eh);
      chk({req, " ppn"}, int'(lk_ppn), ep);
      if (inv) model_clear();
      else if (fe) model_fill(fv, fp);
   endtask

   task automatic look(input string req, input int lv);
      cyc(req, lv, 1'b0, 0, 0, 1'b0);
   endtask

   task automatic fill(input string req, input int fv, input int fp);
      cyc(req, 0, 1'b1, fv, fp, 1'b0);
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state, every page misses
      for (int v = 0; v < 8; v++) look("R9 reset miss", v * 37);

      // R10 / R2: page 0x0F -> 0x0D
      fill("R10 fill", 8'h0F, 6'h0D);
      look("R10 R2 hit 0x03D4", 16'h03D4 >> 6);
      chk("R10 hit", int'(lk_hit), 1);
      chk("R10 pa", (int'(lk_ppn) << 6) | (16'h03D4 & 63), 12'h354);
      // R1: set 3 tag 3 is page 0x0F; same tag other set misses
      look("R1 other set", 8'h0C);
      chk("R1 set split", int'(lk_hit), 0);

      // R10 / R3: 0x0020 misses with other tags in set 0
      fill("R10 fill s0", 8'h04, 6'h11);
      fill("R10 fill s0", 8'h08, 6'h12);
      look("R10 R3 miss 0x0020", 16'h0020 >> 6);
      chk("R3 miss ppn zero", int'(lk_ppn), 0);

      // R4: same-cycle fill and lookup of the same page
      cyc("R4 same cycle", 8'h21, 1'b1, 8'h21, 6'h2A, 1'b0);
      look("R4 next cycle", 8'h21);
      chk("R4 visible", int'(lk_ppn), 6'h2A);

      // R6 / R7: fill set 1 fully, then overflow twice
      fill("R6 fill", 8'h25, 6'h01);
      fill("R6 fill", 8'h29, 6'h02);
      fill("R6 fill", 8'h2D, 6'h03);
      fill("R7 evict", 8'h31, 6'h04);
      fill("R7 evict", 8'h35, 6'h05);
      for (int k = 0; k < 7; k++) look("R7 set1 scan", 8'h21 + 4 * k);

      // R5: refill a present page with a new frame
      fill("R5 refill", 8'h2D, 6'h3F);
      look("R5 refilled", 8'h2D);
      chk("R5 new ppn", int'(lk_ppn), 6'h3F);
      for (int k = 0; k < 7; k++) look("R5 neighbours", 8'h21 + 4 * k);

      // R8: invalidate with a concurrent fill
      cyc("R8 inv+fill", 8'h0F, 1'b1, 8'h3B, 6'h07, 1'b1);
      look("R8 cleared", 8'h0F);
      chk("R8 cleared hit", int'(lk_hit), 0);
      look("R8 fill dropped", 8'h3B);
      chk("R8 dropped hit", int'(lk_hit), 0);

      // R9: mid-run reset
      fill("R9 prefill", 8'h12, 6'h09);
      @(negedge clk);
      rst_n = 1'b0;
      fl_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      look("R9 after reset", 8'h12);
      chk("R9 reset miss", int'(lk_hit), 0);

      // R2 R5 R6 R7 R8: random traffic over a narrow page range
      for (int n = 0; n < 4000; n++) begin
         cyc("R7 random", int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
             int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
             ($urandom_range(0, 63) == 0));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule